// File: doc/BRIEF.md
# Push-Button Register File Editor

This block lets four active-high mechanical push buttons edit a sixteen-entry, eight-bit register file. One pair of buttons moves a selection index up or down. The other pair raises or lowers the value held in the selected entry by one. The current index and the stored value of the selected entry are driven out continuously so that a display stage can show them.

Each raw button line first passes a flop-chain synchroniser. A counter-based debouncer follows it and accepts a new level only after the level has held steady for a set number of clocks. An edge detector then turns every accepted press into a single-cycle event. Index events change the index counter directly. Value events start a two-cycle read-modify-write on a storage array that has a synchronous write port and a registered read address. Reset returns the index to zero and sweeps zeros through the whole array, one entry per clock.

Top module: `btn_regfile_editor`

## Requirements
- R1: A raw button level is accepted only after it has differed from the accepted level for DEB_CYCLES consecutive clocks after synchronisation. A pulse shorter than that, or contact bounce made of segments shorter than that, changes nothing.
- R2: An accepted 0-to-1 transition of a button produces exactly one event lasting one clock. Holding the button or releasing it produces no further event, so one press makes exactly one step.
- R3: An index-up event adds one to sel_idx and an index-down event subtracts one. The index wraps modulo 16, so 0xF+1 gives 0x0 and 0x0-1 gives 0xF.
- R4: A value-up or value-down event adds or subtracts one, modulo 256, on the entry at the current index. The update takes two cycles: a read cycle, then a write cycle that stores the read data plus or minus one. 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R5: Any button event that arrives while a value update is in progress (the read or write cycle) is ignored.
- R6: When the up and down events of the same pair fire in the same clock, both are ignored.
- R7: When a value event and an index event fire in the same clock, the value update runs on the current index and the index event is ignored.
- R8: Reset sets sel_idx to 0 and writes 0x00 to all 16 entries, one entry per clock, starting at entry 0. Button events that fire during this sweep are ignored.
- R9: sel_val shows the stored value of the entry at sel_idx. Because the read address is registered, sel_val follows an index change one clock later, and it follows a completed write on the clock after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| idx_up_btn | input | 1 | Raw button, increments the selection index |
| idx_dn_btn | input | 1 | Raw button, decrements the selection index |
| val_up_btn | input | 1 | Raw button, increments the selected entry |
| val_dn_btn | input | 1 | Raw button, decrements the selected entry |
| sel_idx | output | IDX_W | Currently selected entry index |
| sel_val | output | VAL_W | Stored value of the selected entry |

## Verification
The assertions check several rules on every clock. Each edge event lasts exactly one cycle. The index moves by at most one step per clock and never while an update or the clear sweep is running. A read always leads to a write on the next cycle. The value written back appears on sel_val one clock later. During the clear sweep, zeros go to consecutive addresses. Debounce filtering of bouncy waveforms, the priority and cancellation rules between buttons, wrap-around, and the full array contents against a reference model only show up in the bench's press scenarios and sweeps.

// File: rtl/btnreg_pkg.sv
package btnreg_pkg;

    // Editor sequencing states
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } ed_state_e;

    // Button slot positions inside the conditioned event vector
    localparam int NUM_BTN    = 4;
    localparam int BTN_IDX_UP = 0;
    localparam int BTN_IDX_DN = 1;
    localparam int BTN_VAL_UP = 2;
    localparam int BTN_VAL_DN = 3;

endpackage

// File: rtl/btn_conditioner.sv
// Synchroniser, debouncer and rising-edge one-shot for one button line.
module btn_conditioner #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic press_pulse
);
    localparam int CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEB_CYCLES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   stable;
        logic                   prev;
    } cond_t;

    cond_t cond_d, cond_q;

    always_comb begin
        cond_d      = cond_q;
        cond_d.sync = {cond_q.sync[SYNC_STAGES-2:0], raw_in};
        if (cond_q.sync[SYNC_STAGES-1] != cond_q.stable) begin
            if (cond_q.cnt == CNT_MAX) begin
                cond_d.stable = cond_q.sync[SYNC_STAGES-1];
                cond_d.cnt    = '0;
            end else begin
                cond_d.cnt = cond_q.cnt + 1'b1;
            end
        end else begin
            cond_d.cnt = '0;
        end
        cond_d.prev = cond_q.stable;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
        end else begin
            cond_q <= cond_d;
        end
    end

    assign press_pulse = cond_q.stable & ~cond_q.prev;

endmodule

// File: rtl/edit_ctrl.sv
// Index counter, clear sweep and read-modify-write sequencing.
module edit_ctrl
    import btnreg_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_BTN-1:0] evt,
    input  logic [VAL_W-1:0] rd_data,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] rd_addr,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output logic [VAL_W-1:0] wr_data,
    output ed_state_e        state
);
    localparam logic [IDX_W-1:0] LAST_ADDR = '1;

    typedef struct packed {
        ed_state_e        state;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] clr_addr;
        logic             dir_up;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  val_go, idx_go;

    always_comb begin
        ctrl_d  = ctrl_q;
        wr_en   = 1'b0;
        wr_addr = ctrl_q.idx;
        wr_data = '0;
        // opposing events of one pair cancel each other
        val_go  = evt[BTN_VAL_UP] ^ evt[BTN_VAL_DN];
        idx_go  = evt[BTN_IDX_UP] ^ evt[BTN_IDX_DN];
        unique case (ctrl_q.state)
            ST_CLEAR: begin
                wr_en           = 1'b1;
                wr_addr         = ctrl_q.clr_addr;
                wr_data         = '0;
                ctrl_d.clr_addr = ctrl_q.clr_addr + 1'b1;
                if (ctrl_q.clr_addr == LAST_ADDR) begin
                    ctrl_d.state = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (val_go) begin
                    ctrl_d.state  = ST_READ;
                    ctrl_d.dir_up = evt[BTN_VAL_UP];
                end else if (idx_go) begin
                    ctrl_d.idx = evt[BTN_IDX_UP] ? ctrl_q.idx + 1'b1
                                                 : ctrl_q.idx - 1'b1;
                end
            end
            ST_READ: begin
                ctrl_d.state = ST_WRITE;
            end
            ST_WRITE: begin
                wr_en        = 1'b1;
                wr_data      = ctrl_q.dir_up ? rd_data + 1'b1 : rd_data - 1'b1;
                ctrl_d.state = ST_IDLE;
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{state: ST_CLEAR, idx: '0, clr_addr: '0, dir_up: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign idx     = ctrl_q.idx;
    assign rd_addr = ctrl_q.idx;
    assign state   = ctrl_q.state;

endmodule

// File: rtl/reg_array.sv
// Storage with synchronous write and registered read address.
module reg_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] rd_addr_d, rd_addr_q;

    always_comb begin
        rd_addr_d = rd_addr;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
        rd_addr_q <= rd_addr_d;
    end

    assign rd_data = mem_q[rd_addr_q];

endmodule

// File: rtl/btn_regfile_editor.sv
module btn_regfile_editor
    import btnreg_pkg::*;
#(
    parameter int IDX_W       = 4,
    parameter int VAL_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 65536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_up_btn,
    input  logic             idx_dn_btn,
    input  logic             val_up_btn,
    input  logic             val_dn_btn,
    output logic [IDX_W-1:0] sel_idx,
    output logic [VAL_W-1:0] sel_val
);
    logic [NUM_BTN-1:0] raw_vec;
    logic [NUM_BTN-1:0] btn_evt;
    logic [IDX_W-1:0]   rd_addr;
    logic [IDX_W-1:0]   wr_addr;
    logic [VAL_W-1:0]   wr_data;
    logic [VAL_W-1:0]   rd_data;
    logic               wr_en;
    ed_state_e          ed_state;

    always_comb begin
        raw_vec             = '0;
        raw_vec[BTN_IDX_UP] = idx_up_btn;
        raw_vec[BTN_IDX_DN] = idx_dn_btn;
        raw_vec[BTN_VAL_UP] = val_up_btn;
        raw_vec[BTN_VAL_DN] = val_dn_btn;
    end

    for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
        btn_conditioner #(
            .SYNC_STAGES (SYNC_STAGES),
            .DEB_CYCLES  (DEB_CYCLES)
        ) u_cond (
            .clk         (clk),
            .rst         (rst),
            .raw_in      (raw_vec[b]),
            .press_pulse (btn_evt[b])
        );
    end

    edit_ctrl #(
        .IDX_W (IDX_W),
        .VAL_W (VAL_W)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .evt     (btn_evt),
        .rd_data (rd_data),
        .idx     (sel_idx),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .state   (ed_state)
    );

    reg_array #(
        .ADDR_W (IDX_W),
        .DATA_W (VAL_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign sel_val = rd_data;

endmodule

// File: rtl/btn_regfile_editor_chk.sv
module btn_regfile_editor_chk
    import btnreg_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int VAL_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_BTN-1:0] evt,
    input ed_state_e          state,
    input logic [IDX_W-1:0]   sel_idx,
    input logic [VAL_W-1:0]   sel_val,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_addr,
    input logic [VAL_W-1:0]   wr_data
);
    // R2
    evt_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((evt & $past(evt)) == '0));

    // R3
    idx_single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (sel_idx == $past(sel_idx)
               || sel_idx == IDX_W'($past(sel_idx) + 1'b1)
               || sel_idx == IDX_W'($past(sel_idx) - 1'b1)));

    // R5
    idx_frozen_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(sel_idx));

    // R4
    read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ) |=> (state == ST_WRITE && wr_en && wr_addr == sel_idx));

    // R9
    writeback_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE) |=> (sel_val == $past(wr_data)));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLEAR) |-> (wr_en && wr_data == '0 && sel_idx == '0));

    // R8
    clear_sweep_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLEAR && $past(state) == ST_CLEAR && !$past(rst))
            |-> (wr_addr == IDX_W'($past(wr_addr) + 1'b1)));

endmodule

bind btn_regfile_editor btn_regfile_editor_chk #(
    .IDX_W (IDX_W),
    .VAL_W (VAL_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .evt     (btn_evt),
    .state   (ed_state),
    .sel_idx (sel_idx),
    .sel_val (sel_val),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
);

// File: tb/tb_btn_regfile_editor.sv
module tb_btn_regfile_editor;
    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 8;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] btn = 4'b0;   // [0] idx up, [1] idx down, [2] value up, [3] value down
    logic [3:0] sel_idx;
    logic [7:0] sel_val;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [7:0] m_mem [16];
    logic [3:0] m_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    btn_regfile_editor #(
        .IDX_W       (4),
        .VAL_W       (8),
        .SYNC_STAGES (2),
        .DEB_CYCLES  (DEB)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .idx_up_btn (btn[0]),
        .idx_dn_btn (btn[1]),
        .val_up_btn (btn[2]),
        .val_dn_btn (btn[3]),
        .sel_idx    (sel_idx),
        .sel_val    (sel_val)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_lvl(input logic [3:0] mask, input bit lvl);
        btn = lvl ? (btn | mask) : (btn & ~mask);
    endtask

    // drive a transition with nb bounce segments, each shorter than DEB
    task automatic drive(input logic [3:0] mask, input bit lvl, input int nb);
        for (int k = 0; k < nb; k++) begin
            set_lvl(mask, lvl);
            wait_cyc(1 + int'($urandom % (DEB - 2)));
            set_lvl(mask, !lvl);
            wait_cyc(1 + int'($urandom % (DEB - 2)));
        end
        set_lvl(mask, lvl);
        wait_cyc(2 * DEB + 8);
    endtask

    function automatic void model_apply(input logic [3:0] ev);
        bit vgo = ev[2] ^ ev[3];
        bit igo = ev[0] ^ ev[1];
        if (vgo) m_mem[m_idx] = ev[2] ? m_mem[m_idx] + 8'd1 : m_mem[m_idx] - 8'd1;
        else if (igo) m_idx = ev[0] ? m_idx + 4'd1 : m_idx - 4'd1;
    endfunction

    task automatic press(input logic [3:0] mask, input int nb, input string tag);
        drive(mask, 1'b1, nb);
        drive(mask, 1'b0, nb);
        model_apply(mask);
        check({tag, " idx"}, sel_idx, m_idx);
        check({tag, " val"}, sel_val, m_mem[m_idx]);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        m_idx = 4'd0;
        for (int e = 0; e < 16; e++) m_mem[e] = 8'h00;
    endtask

    // R9: step through all entries and compare each against the model
    task automatic sweep(input string tag);
        for (int e = 0; e < 16; e++) press(4'b0001, 0, {tag, " R9 sweep"});
    endtask

    initial begin
        wait_cyc(WATCHDOG);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        wait_cyc(1);
        check("R8 idx during clear", sel_idx, 0);
        wait_cyc(30);
        check("R8 idx after reset", sel_idx, 0);
        check("R8 val after reset", sel_val, 0);
        sweep("R8 cleared");

        // R3/R4 wrap at both ends
        press(4'b0010, 0, "R3 idx 0 down wraps");
        check("R3 wrap to F", sel_idx, 15);
        press(4'b1000, 0, "R4 val 00 down wraps");
        check("R4 wrap to FF", sel_val, 8'hFF);
        press(4'b0100, 0, "R4 val FF up wraps");
        check("R4 wrap to 00", sel_val, 8'h00);
        press(4'b0001, 0, "R3 idx F up wraps");
        check("R3 wrap to 0", sel_idx, 0);

        // R1 glitch shorter than the debounce window
        btn[0] = 1'b1; wait_cyc(DEB - 2); btn[0] = 1'b0; wait_cyc(3 * DEB);
        check("R1 short glitch idx", sel_idx, m_idx);

        // R2 long hold gives one step
        btn[2] = 1'b1; wait_cyc(10 * DEB); btn[2] = 1'b0; wait_cyc(3 * DEB);
        model_apply(4'b0100);
        check("R2 held press one step", sel_val, m_mem[m_idx]);

        // R6 opposing pairs together
        press(4'b0011, 2, "R6 idx pair cancels");
        press(4'b1100, 2, "R6 val pair cancels");

        // R7 value beats index in the same clock
        press(4'b0101, 1, "R7 value wins");

        // R5 index event one clock after a value event is ignored
        btn[2] = 1'b1; wait_cyc(1); btn[1] = 1'b1;
        wait_cyc(3 * DEB);
        btn[2] = 1'b0; btn[1] = 1'b0;
        wait_cyc(3 * DEB);
        m_mem[m_idx] = m_mem[m_idx] + 8'd1;
        check("R5 idx ignored while busy", sel_idx, m_idx);
        check("R5 value updated", sel_val, m_mem[m_idx]);

        // R1/R2/R3/R4 random bouncy presses
        for (int n = 0; n < 80; n++) begin
            logic [3:0] mk;
            int sel = int'($urandom % 10);
            case (sel)
                0, 1, 2: mk = 4'b0001;
                3:       mk = 4'b0010;
                4, 5:    mk = 4'b0100;
                6, 7:    mk = 4'b1000;
                8:       mk = 4'b0011;
                default: mk = 4'b1100;
            endcase
            press(mk, int'($urandom % 4), "R1 R3 R4 random");
        end
        sweep("R4 after random");

        // R8 reset mid-way with buttons held: events during clear are ignored
        btn = 4'b0101;
        do_reset();
        wait_cyc(4 * DEB);
        check("R8 held press during clear idx", sel_idx, 0);
        check("R8 held press during clear val", sel_val, 0);
        btn = 4'b0000;
        wait_cyc(3 * DEB);
        check("R2 release no event", sel_idx, 0);
        sweep("R8 after second reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule